// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock, separate from the bus clock that programs it. A 12-bit down counter is advanced by a programmable power-of-two prescaler. Whenever a prescaled tick finds the counter already at zero while the watchdog is running, a one-cycle reset request is raised in the watchdog clock domain. After that request the counter reloads and keeps running, so an ignored timeout repeats until the system reset clears the block.

Software controls the block only through 16-bit magic values written to a key register. One value unlocks the prescaler and reload registers for writing. One refreshes the counter from the reload value. One starts the watchdog. Nothing can stop the watchdog once it is running. A strap input can also start it straight out of reset.

Every update to the configuration registers, and every refresh or start command, crosses into the watchdog domain through a toggle handshake with two-flop synchronizers. The status register shows a busy bit for each configuration register until its handshake completes.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the prescaler reads 0, the reload register reads 0xFFF and the status reads 0. The counter holds 0xFFF, so a start with no refresh times out 4096 ticks of divide-by-4 later (16384 watchdog clock cycles, plus synchronizer latency).
- R2: While the watchdog is running, a prescaled tick that finds the counter at zero raises `rst_req` for exactly one watchdog clock cycle and reloads the counter from the reload value. A refresh therefore leads to a timeout after (reload+1) × ratio watchdog cycles, and an ignored timeout repeats with that same period.
- R3: Writing 0xAAAA to the key register (address 0) loads the counter from the reload value and restarts the prescaler phase, which postpones the timeout.
- R4: Writing 0xCCCC to the key register starts the watchdog. While it is not started, `rst_req` stays low.
- R5: Once started, the watchdog keeps running whatever is written to the key register.
- R6: The prescaler register (address 1, bits [2:0]) selects divide-by-(4 << code) for codes 0 to 6. Code 7 selects divide-by-256.
- R7: The reload register (address 2, bits [11:0]) accepts any value from 0 to 0xFFF and reads back what was written.
- R8: Writes to the prescaler and reload registers take effect only after 0x5555 has been written to the key register. Writing 0xAAAA or 0xCCCC locks them again. Any other key value leaves the lock state unchanged.
- R9: In the status register (address 3), bit 0 is high while a prescaler update is in flight and bit 1 is high while a reload update is in flight. Each bit is set from the cycle after the accepted write until the handshake completes. A write to a register whose update is still in flight is ignored.
- R10: With `hw_start` high during reset, the watchdog runs from reset without any key write.
- R11: The key register reads as zero. Bits above each field's width read as zero, and write data in those bits is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe for one bus cycle |
| addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| wdg_clk | input | 1 | Watchdog low-speed clock |
| wdg_rst_n | input | 1 | Synchronous active-low reset, watchdog domain |
| hw_start | input | 1 | Strap: run from reset without a start key |
| rst_req | output | 1 | One-cycle reset request, watchdog domain |

## Verification
The assertions rely on both resets being applied together. They also rely on the prescaler never dividing by less than 4, so two ticks can never fall on adjacent watchdog cycles. The stimulus always asserts the two resets at the same time and holds each for several cycles of both clocks. It sends the next configuration write only after the status register has dropped the busy bit. A single directed case writes into a busy register on purpose, to show that the write is ignored. The bench keeps its timing windows a few cycles wide, because the handshake latency depends on the phase between the two clocks.

// File: rtl/wdg_pkg.sv
// Shared constants for the key-protected watchdog.
// Assumes a 16-bit register data path and a 2-bit register address.
package wdg_pkg;
    localparam int DATA_W = 16;

    // Magic key values (the block's behaviour decodes these exact codes)
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [1:0] {
        A_KEY  = 2'd0,
        A_PRE  = 2'd1,
        A_RLD  = 2'd2,
        A_STAT = 2'd3
    } wdg_addr_e;

    // Event indices crossing bus -> watchdog domain
    localparam int EV_PRE     = 0;
    localparam int EV_RLD     = 1;
    localparam int EV_REFRESH = 2;
    localparam int EV_START   = 3;
    localparam int EV_NUM     = 4;
endpackage

// File: rtl/wdg_evt_sync.sv
// Carries single-cycle events from a source clock domain to a destination
// domain with a toggle request and a toggle acknowledge, each passed through
// a STAGES-deep synchronizer. A pulse that arrives while a transfer is in
// flight is queued and sent once the acknowledge returns, so events merge
// and are never lost.
// Assumes both resets are applied together.
module wdg_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    output logic src_busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              req_t;
    logic              queued;
    logic [STAGES-1:0] ack_sync;
    logic [STAGES-1:0] req_sync;
    logic              seen;
    logic              idle;

    assign idle     = (req_t == ack_sync[STAGES-1]);
    assign src_busy = !idle || queued;

    // Toggle the request when idle; otherwise remember the pulse
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            req_t  <= 1'b0;
            queued <= 1'b0;
        end else if (idle) begin
            if (src_pulse || queued) begin
                req_t  <= ~req_t;
                queued <= 1'b0;
            end
        end else if (src_pulse) begin
            queued <= 1'b1;
        end
    end

    // Bring the acknowledge back into the source domain
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) ack_sync <= '0;
        else            ack_sync <= {ack_sync[STAGES-2:0], seen};
    end

    // Synchronize the request into the destination domain
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) req_sync <= '0;
        else            req_sync <= {req_sync[STAGES-2:0], req_t};
    end

    // Remember the last request level seen; this is also the acknowledge
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) seen <= 1'b0;
        else            seen <= req_sync[STAGES-1];
    end

    assign dst_pulse = req_sync[STAGES-1] ^ seen;

    // R9
    evt_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/wdg_bus_regs.sv
// Bus-side register file: decodes keys, holds the write lock, stores the
// prescaler and reload values and raises the events that cross to the
// watchdog domain.
// Assumes wr_en is a single-cycle strobe and that reads have no side effects.
module wdg_bus_regs import wdg_pkg::*; #(
    parameter int CNT_W = 12,
    parameter int PRE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pre_busy,
    input  logic              rld_busy,
    output logic [DATA_W-1:0] rdata,
    output logic [PRE_W-1:0]  pre_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic [EV_NUM-1:0] ev_pulse
);
    logic unlocked;
    logic key_wr;
    logic pre_acc;
    logic rld_acc;

    assign key_wr  = wr_en && (addr == A_KEY);
    assign pre_acc = wr_en && (addr == A_PRE) && unlocked && !pre_busy;
    assign rld_acc = wr_en && (addr == A_RLD) && unlocked && !rld_busy;

    // Lock state: unlocked by the unlock key, relocked by refresh or start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            if (wdata == KEY_UNLOCK)
                unlocked <= 1'b1;
            else if (wdata == KEY_REFRESH || wdata == KEY_START)
                unlocked <= 1'b0;
        end
    end

    // Configuration storage, written only when accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            rld_q <= '1;
        end else begin
            if (pre_acc) pre_q <= wdata[PRE_W-1:0];
            if (rld_acc) rld_q <= wdata[CNT_W-1:0];
        end
    end

    // Events handed to the synchronizers
    always_comb begin
        ev_pulse             = '0;
        ev_pulse[EV_PRE]     = pre_acc;
        ev_pulse[EV_RLD]     = rld_acc;
        ev_pulse[EV_REFRESH] = key_wr && (wdata == KEY_REFRESH);
        ev_pulse[EV_START]   = key_wr && (wdata == KEY_START);
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            A_PRE:   rdata = {{(DATA_W-PRE_W){1'b0}}, pre_q};
            A_RLD:   rdata = {{(DATA_W-CNT_W){1'b0}}, rld_q};
            A_STAT:  rdata = {{(DATA_W-2){1'b0}}, rld_busy, pre_busy};
            default: rdata = '0;
        endcase
    end

    // R8
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(pre_q) && $stable(rld_q)));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_busy && rld_busy) |=> ($stable(pre_q) && $stable(rld_q)));
endmodule

// File: rtl/wdg_counter_core.sv
// Watchdog-domain core: the prescaler divider, the 12-bit down counter, the
// sticky run flag and the reset request. Configuration copies are taken from
// bus-domain registers when an update event arrives; those registers hold
// still while their handshake is in flight, so a multi-bit capture is safe.
// Assumes hw_start is a static strap.
module wdg_counter_core import wdg_pkg::*; #(
    parameter int CNT_W    = 12,
    parameter int PRE_W    = 3,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_start,
    input  logic [EV_NUM-1:0] ev_in,
    input  logic [PRE_W-1:0]  pre_src,
    input  logic [CNT_W-1:0]  rld_src,
    output logic              rst_req
);
    localparam int DIV_W    = MAX_LOG2;
    localparam int MAX_CODE = MAX_LOG2 - MIN_LOG2;

    // Terminal divider count for a prescaler code; large codes saturate
    function automatic logic [DIV_W-1:0] term_of(input logic [PRE_W-1:0] code);
        int sh;
        sh = (int'(code) > MAX_CODE) ? MAX_LOG2 : int'(code) + MIN_LOG2;
        return DIV_W'((32'd1 << sh) - 32'd1);
    endfunction

    logic [PRE_W-1:0] pre_w;
    logic [CNT_W-1:0] rld_w;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             refresh;
    logic             tick;

    assign refresh = ev_in[EV_REFRESH];
    assign tick    = running && (div_cnt >= term_of(pre_w));

    // Local copies of the configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_w <= '0;
            rld_w <= '1;
        end else begin
            if (ev_in[EV_PRE]) pre_w <= pre_src;
            if (ev_in[EV_RLD]) rld_w <= rld_src;
        end
    end

    // Run flag: set by strap or start key, never cleared
    always_ff @(posedge clk) begin
        if (!rst_n)              running <= hw_start;
        else if (ev_in[EV_START]) running <= 1'b1;
    end

    // Prescaler divider; phase restarts on refresh or start
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (!running || refresh || ev_in[EV_START] || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DIV_W'(1);
    end

    // Down counter: reload on refresh or on expiry, else count ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (refresh)
            cnt <= rld_w;
        else if (tick)
            cnt <= (cnt == '0) ? rld_w : cnt - CNT_W'(1);
    end

    // Reset request: one cycle per expiry
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= tick && (cnt == '0) && !refresh;
    end

    // R5
    running_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
    // R2
    expiry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(cnt) == '0 && $past(running)));
    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !refresh) |=> $stable(cnt));
endmodule

// File: rtl/keyed_watchdog.sv
// Top of the key-protected watchdog: bus-side registers, one handshake
// synchronizer per crossing event, and the watchdog-domain counter core.
// Assumes bus_rst_n and wdg_rst_n are asserted together.
module keyed_watchdog import wdg_pkg::*; #(
    parameter int CNT_W       = 12,
    parameter int PRE_W       = 3,
    parameter int MIN_LOG2    = 2,
    parameter int MAX_LOG2    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wdg_clk,
    input  logic              wdg_rst_n,
    input  logic              hw_start,
    output logic              rst_req
);
    logic [EV_NUM-1:0] ev_src;
    logic [EV_NUM-1:0] ev_busy;
    logic [EV_NUM-1:0] ev_dst;
    logic [PRE_W-1:0]  pre_q;
    logic [CNT_W-1:0]  rld_q;
    logic              key_inflight_unused;

    // Key events queue internally; their busy state is not reported
    assign key_inflight_unused = ev_busy[EV_REFRESH] | ev_busy[EV_START];

    wdg_bus_regs #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) u_regs (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pre_busy (ev_busy[EV_PRE]),
        .rld_busy (ev_busy[EV_RLD]),
        .rdata    (rdata),
        .pre_q    (pre_q),
        .rld_q    (rld_q),
        .ev_pulse (ev_src)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_ev
        wdg_evt_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .src_clk   (bus_clk),
            .src_rst_n (bus_rst_n),
            .src_pulse (ev_src[g]),
            .src_busy  (ev_busy[g]),
            .dst_clk   (wdg_clk),
            .dst_rst_n (wdg_rst_n),
            .dst_pulse (ev_dst[g])
        );
    end

    wdg_counter_core #(
        .CNT_W    (CNT_W),
        .PRE_W    (PRE_W),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_core (
        .clk      (wdg_clk),
        .rst_n    (wdg_rst_n),
        .hw_start (hw_start),
        .ev_in    (ev_dst),
        .pre_src  (pre_q),
        .rld_src  (rld_q),
        .rst_req  (rst_req)
    );
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
    localparam int BUS_PERIOD = 10;
    localparam int WDG_PERIOD = 30;
    localparam int WATCHDOG_CYC = 150000;

    logic        bus_clk = 1'b0;
    logic        wdg_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        wdg_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        hw_start = 1'b0;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int bus_cyc = 0;

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(WDG_PERIOD/2) wdg_clk = ~wdg_clk;

    keyed_watchdog u0 (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n),
        .hw_start(hw_start), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [1:0]  wa;
        logic [15:0] wd;
        logic [1:0]  ra;
        logic [15:0] ex;
    } vec_t;

    // write address/data, then read address and expected value
    localparam vec_t VEC [12] = '{
        '{2'd1, 16'h0005, 2'd1, 16'h0000},  // R8 locked prescaler write
        '{2'd2, 16'h0123, 2'd2, 16'h0FFF},  // R8 locked reload write
        '{2'd0, 16'h5555, 2'd0, 16'h0000},  // R11 key reads zero
        '{2'd0, 16'h1234, 2'd3, 16'h0000},  // R8 unknown key keeps lock
        '{2'd1, 16'hFFFD, 2'd1, 16'h0005},  // R6 R11 upper bits dropped
        '{2'd2, 16'hF123, 2'd2, 16'h0123},  // R7 R11
        '{2'd0, 16'hAAAA, 2'd2, 16'h0123},  // R3 refresh relocks
        '{2'd2, 16'h0456, 2'd2, 16'h0123},  // R8 relocked
        '{2'd0, 16'h5555, 2'd1, 16'h0005},  // R8 unlock again
        '{2'd2, 16'h0FFF, 2'd2, 16'h0FFF},  // R7 maximum
        '{2'd1, 16'h0007, 2'd1, 16'h0007},  // R6 top code
        '{2'd2, 16'h0000, 2'd2, 16'h0000}   // R7 minimum
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic do_reset(input logic strap);
        hw_start = strap;
        @(negedge bus_clk);
        bus_rst_n = 1'b0;
        wdg_rst_n = 1'b0;
        repeat (5) @(negedge wdg_clk);
        @(negedge bus_clk);
        bus_rst_n = 1'b1;
        wdg_rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 100; i++) begin
            @(negedge bus_clk);
            bus_read(2'd3, s);
            if (s == 16'd0) break;
        end
    endtask

    // Count watchdog cycles until rst_req is seen; -1 if never within limit
    task automatic wait_rst(input int limit, output int n);
        n = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge wdg_clk);
            if (rst_req) begin
                n = i + 1;
                break;
            end
        end
    endtask

    task automatic configure(input int code, input int rl);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'(code));
        wait_idle();
        bus_write(2'd2, 16'(rl));
        wait_idle();
    endtask

    task automatic run_timeout(input int code, input int rl, input int ratio);
        int n;
        int exp;
        exp = (rl + 1) * ratio;
        do_reset(1'b0);
        configure(code, rl);
        bus_write(2'd0, 16'hAAAA);
        bus_write(2'd0, 16'hCCCC);
        wait_rst(exp + 60, n);
        chk_rng("R2 R6 timeout period", n, exp, exp + 8);
    endtask

    always @(posedge bus_clk) begin
        bus_cyc++;
        if (bus_cyc > WATCHDOG_CYC) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int n;

        // Reset state, R1 and R11
        do_reset(1'b0);
        @(negedge bus_clk);
        bus_read(2'd1, rd); chk("R1 prescaler reset", rd, 0);
        bus_read(2'd2, rd); chk("R1 reload reset", rd, 16'h0FFF);
        bus_read(2'd3, rd); chk("R1 status reset", rd, 0);
        bus_read(2'd0, rd); chk("R11 key reads zero", rd, 0);
        chk("R4 no request after reset", rst_req, 0);

        // Vector walk over lock and field behaviour
        for (int i = 0; i < 12; i++) begin
            bus_write(VEC[i].wa, VEC[i].wd);
            wait_idle();
            @(negedge bus_clk);
            bus_read(VEC[i].ra, rd);
            chk($sformatf("R8 vector %0d", i), rd, VEC[i].ex);
        end

        // R9: busy flags and writes while busy
        do_reset(1'b0);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0002);
        bus_read(2'd3, rd); chk("R9 prescaler busy bit", rd, 1);
        bus_write(2'd1, 16'h0006);
        wait_idle();
        bus_read(2'd1, rd); chk("R9 write while busy ignored", rd, 2);
        bus_write(2'd2, 16'h0010);
        bus_read(2'd3, rd); chk("R9 reload busy bit", rd, 2);
        wait_idle();
        bus_read(2'd3, rd); chk("R9 busy clears", rd, 0);

        // R2 R6 timeout periods under several codes and reload values
        run_timeout(0, 5, 4);
        run_timeout(2, 3, 16);
        run_timeout(7, 1, 256);
        run_timeout(6, 0, 256);

        // R4: refresh without start never times out
        do_reset(1'b0);
        configure(0, 1);
        bus_write(2'd0, 16'hAAAA);
        wait_rst(200, n);
        chk("R4 not started no request", n, -1);

        // R3: refresh postpones the timeout
        do_reset(1'b0);
        configure(0, 9);
        bus_write(2'd0, 16'hAAAA);
        bus_write(2'd0, 16'hCCCC);
        wait_rst(25, n);
        chk("R3 no early request", n, -1);
        bus_write(2'd0, 16'hAAAA);
        wait_rst(120, n);
        chk_rng("R3 refresh restarts period", n, 40, 48);

        // R5: junk keys cannot stop it; R2 pulse width and repeat period
        do_reset(1'b0);
        configure(0, 7);
        bus_write(2'd0, 16'hAAAA);
        bus_write(2'd0, 16'hCCCC);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'hFFFF);
        bus_write(2'd0, 16'h5555);
        wait_rst(120, n);
        chk_rng("R5 still running after junk keys", n, 28, 40);
        @(negedge wdg_clk);
        chk("R2 request one cycle wide", rst_req, 0);
        wait_rst(120, n);
        chk("R2 repeat period", n, 31);

        // R10: strap start, no start key
        do_reset(1'b1);
        configure(0, 2);
        bus_write(2'd0, 16'hAAAA);
        wait_rst(100, n);
        chk_rng("R10 strap start timeout", n, 12, 20);
        @(negedge wdg_clk);
        wait_rst(100, n);
        chk("R10 repeat period", n, 11);

        // R1: default counter value after start alone
        do_reset(1'b0);
        bus_write(2'd0, 16'hCCCC);
        wait_rst(17000, n);
        chk_rng("R1 default timeout", n, 16384, 16392);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule